// File: doc/BRIEF.md
# Bit-Granular Mask Chaining Scoreboard

This block tracks when the bits of a 64-bit integer register used as a vector mask become ready. It tracks each bit, so that dependent vector operations can chain group by group and need not wait for the whole register. It models three issue slots. The first is a 4-lane SIMD integer compare that writes the source mask. The second is a scalar logic unit that merges that mask with a second, already-valid mask as `a AND NOT b`, producing the destination mask. The third is a 4-lane SIMD floating-point add that is predicated by the destination mask. No data is computed: the block models only readiness and issue timing.

Each mask register keeps one pending bit per element. A start pulse for a producer sets the pending bits below the vector length, and each issued group of the producer clears its own bits. A consumer group may issue once all of its source bits are clear. A mode input selects whole-register waiting instead, so that the two schedules can be compared. All three units may issue in the same cycle, and each issues at most one group per cycle, in ascending order.

Top module: `mask_chain_sb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no issue strobe and no done are asserted.
- R2: The cycle after `start_cmp` is sampled with a non-zero vector length is cycle 0. The compare issues group k in cycle k, for k from 0 to G-1, where G = ceil(VL/4).
- R3: Group k covers elements 4k to 4k+3. `fadd_lanes` bit i is 1 when element 4k+i is below VL, so only the last group can be partial.
- R4: In per-bit mode (`whole_mode`=0 at `start_cmp`), the combine issues group k in the first cycle that satisfies three conditions: it is after the cycle of compare group k, it is after the cycle of combine group k-1, and the combine has been started. With all starts together and VL=20, it issues in cycles 1 to 5.
- R5: In per-bit mode, the FP add issues group k in the first cycle that is after combine group k and after FP group k-1. With all starts together and VL=20, it issues in cycles 2 to 6, and in cycle 2 all three units issue.
- R6: In whole-register mode, the combine waits until every compare group is written. It then issues once, with `comb_whole`=1 and group 0 (in cycle 5 for VL=20).
- R7: In whole-register mode, the FP add issues its groups in consecutive cycles starting the cycle after the combine (cycles 6 to 10 for VL=20).
- R8: `done` is high for exactly one cycle, the cycle after the last FP group issues.
- R9: A start pulse with VL=0 has no effect: no issue strobe and no done follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vl | input | 7 | Vector length in elements, 0 to 64, sampled with each start |
| whole_mode | input | 1 | 1 selects whole-register waiting, sampled with `start_cmp` |
| start_cmp | input | 1 | Launches the SIMD compare that writes the source mask |
| start_comb | input | 1 | Launches the mask combine that writes the destination mask |
| start_fadd | input | 1 | Launches the masked SIMD FP add |
| cmp_issue | output | 1 | Compare issues a group this cycle |
| cmp_group | output | 4 | Group index of the compare issue |
| comb_issue | output | 1 | Combine issues this cycle |
| comb_whole | output | 1 | The combine issue covers the whole register |
| comb_group | output | 4 | Group index of the combine issue |
| fadd_issue | output | 1 | FP add issues a group this cycle |
| fadd_group | output | 4 | Group index of the FP add issue |
| fadd_lanes | output | 4 | Active lanes of the FP add group |
| done | output | 1 | One-cycle pulse after the last FP group |

## Verification
A pending bit that is left set shows up as a consumer group that never issues, and the run then misses its done pulse. A pending bit that is cleared too early shows up as a combine or FP issue one or more cycles before its producer group. Both errors appear at the ports within a cycle of the affected group. The bench records the issue cycle of every group of every unit and compares each one with schedules it computes itself. It does this for both modes, for full and partial final groups, for a staggered start and for the longest vector. A miscounted group limit therefore shows up as a missing issue or an extra issue.

// File: rtl/mask_chain_sb.sv
module mask_chain_sb #(
  parameter int REG_BITS = 64,
  parameter int LANES    = 4,
  parameter int VLW      = $clog2(REG_BITS + 1)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [VLW-1:0]                        vl,
  input  logic                                  whole_mode,
  input  logic                                  start_cmp,
  input  logic                                  start_comb,
  input  logic                                  start_fadd,
  output logic                                  cmp_issue,
  output logic [$clog2(REG_BITS/LANES)-1:0]     cmp_group,
  output logic                                  comb_issue,
  output logic                                  comb_whole,
  output logic [$clog2(REG_BITS/LANES)-1:0]     comb_group,
  output logic                                  fadd_issue,
  output logic [$clog2(REG_BITS/LANES)-1:0]     fadd_group,
  output logic [LANES-1:0]                      fadd_lanes,
  output logic                                  done
);
  localparam int GROUPS = REG_BITS / LANES;
  localparam int GW     = $clog2(GROUPS);
  localparam int LSH    = $clog2(LANES);

  logic [REG_BITS-1:0] pend_a, pend_c, pa_n, pc_n, vl_mask;
  logic [VLW-1:0]      vl_eff, vl_m1, fadd_vl;
  logic [GW-1:0]       cmp_g, comb_g, fadd_g, last_in;
  logic [GW-1:0]       cmp_last, comb_last, fadd_last;
  logic                cmp_act, comb_act, fadd_act, whole_q;
  logic                vl_nz, comb_rdy, fadd_rdy;
  logic [LANES-1:0]    a_grp, c_grp;

  assign vl_eff  = (int'(vl) > REG_BITS) ? VLW'(REG_BITS) : vl;
  assign vl_nz   = vl_eff != '0;
  assign vl_m1   = vl_eff - 1'b1;
  assign last_in = GW'(vl_m1 >> LSH);

  always_comb
    for (int i = 0; i < REG_BITS; i++)
      vl_mask[i] = i < int'(vl_eff);

  assign a_grp    = pend_a[comb_g*LANES +: LANES];
  assign c_grp    = pend_c[fadd_g*LANES +: LANES];
  assign comb_rdy = whole_q ? (pend_a == '0) : (a_grp == '0);
  assign fadd_rdy = whole_q ? (pend_c == '0) : (c_grp == '0);

  assign cmp_issue  = cmp_act;
  assign cmp_group  = cmp_g;
  assign comb_issue = comb_act && comb_rdy;
  assign comb_whole = whole_q;
  assign comb_group = whole_q ? '0 : comb_g;
  assign fadd_issue = fadd_act && fadd_rdy;
  assign fadd_group = fadd_g;

  always_comb
    for (int i = 0; i < LANES; i++)
      fadd_lanes[i] = (int'(fadd_g) * LANES + i) < int'(fadd_vl);

  always_comb begin
    pa_n = pend_a;
    pc_n = pend_c;
    if (cmp_issue)
      pa_n[cmp_g*LANES +: LANES] = '0;
    if (comb_issue) begin
      if (whole_q) pc_n = '0;
      else         pc_n[comb_g*LANES +: LANES] = '0;
    end
    if (start_cmp  && vl_nz) pa_n = pa_n | vl_mask;
    if (start_comb && vl_nz) pc_n = pc_n | vl_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_a    <= '0;
      pend_c    <= '0;
      cmp_act   <= 1'b0;
      comb_act  <= 1'b0;
      fadd_act  <= 1'b0;
      whole_q   <= 1'b0;
      cmp_g     <= '0;
      comb_g    <= '0;
      fadd_g    <= '0;
      cmp_last  <= '0;
      comb_last <= '0;
      fadd_last <= '0;
      fadd_vl   <= '0;
      done      <= 1'b0;
    end else begin
      pend_a <= pa_n;
      pend_c <= pc_n;
      done   <= fadd_issue && (fadd_g == fadd_last);

      if (cmp_issue) begin
        if (cmp_g == cmp_last) cmp_act <= 1'b0;
        else                   cmp_g   <= cmp_g + 1'b1;
      end
      if (start_cmp && vl_nz) begin
        cmp_act  <= 1'b1;
        cmp_g    <= '0;
        cmp_last <= last_in;
        whole_q  <= whole_mode;
      end

      if (comb_issue) begin
        if (whole_q || comb_g == comb_last) comb_act <= 1'b0;
        else                                comb_g   <= comb_g + 1'b1;
      end
      if (start_comb && vl_nz) begin
        comb_act  <= 1'b1;
        comb_g    <= '0;
        comb_last <= last_in;
      end

      if (fadd_issue) begin
        if (fadd_g == fadd_last) fadd_act <= 1'b0;
        else                     fadd_g   <= fadd_g + 1'b1;
      end
      if (start_fadd && vl_nz) begin
        fadd_act  <= 1'b1;
        fadd_g    <= '0;
        fadd_last <= last_in;
        fadd_vl   <= vl_eff;
      end
    end
  end
endmodule

// File: rtl/mask_chain_sb_chk.sv
module mask_chain_sb_chk #(
  parameter int REG_BITS = 64,
  parameter int LANES    = 4,
  parameter int GW       = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmp_issue,
  input logic [GW-1:0]       cmp_group,
  input logic                comb_issue,
  input logic                comb_whole,
  input logic [GW-1:0]       comb_group,
  input logic                fadd_issue,
  input logic [GW-1:0]       fadd_group,
  input logic [LANES-1:0]    fadd_lanes,
  input logic                done,
  input logic [REG_BITS-1:0] pend_a,
  input logic [REG_BITS-1:0] pend_c
);
  a_r2_cmp_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_issue && cmp_group != '0 |-> $past(cmp_issue) && GW'($past(cmp_group) + 1'b1) == cmp_group);

  a_r4_comb_src_written: assert property (@(posedge clk) disable iff (!rst_n)
    comb_issue && !comb_whole |-> pend_a[comb_group*LANES +: LANES] == '0);

  a_r6_whole_src_clear: assert property (@(posedge clk) disable iff (!rst_n)
    comb_issue && comb_whole |-> pend_a == '0);

  a_r5_fadd_mask_ready: assert property (@(posedge clk) disable iff (!rst_n)
    fadd_issue |-> pend_c[fadd_group*LANES +: LANES] == '0);

  a_r3_lane_zero_active: assert property (@(posedge clk) disable iff (!rst_n)
    fadd_issue |-> fadd_lanes[0]);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_fadd: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fadd_issue));
endmodule

bind mask_chain_sb mask_chain_sb_chk #(.REG_BITS(REG_BITS), .LANES(LANES), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmp_issue(cmp_issue), .cmp_group(cmp_group),
  .comb_issue(comb_issue), .comb_whole(comb_whole), .comb_group(comb_group),
  .fadd_issue(fadd_issue), .fadd_group(fadd_group), .fadd_lanes(fadd_lanes),
  .done(done), .pend_a(pend_a), .pend_c(pend_c)
);

// File: tb/mask_chain_sb_test.sv
module mask_chain_sb_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] vl = '0;
  logic       whole_mode = 1'b0;
  logic       start_cmp = 1'b0, start_comb = 1'b0, start_fadd = 1'b0;
  logic       cmp_issue, comb_issue, comb_whole, fadd_issue, done;
  logic [3:0] cmp_group, comb_group, fadd_group, fadd_lanes;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  mask_chain_sb uut (
    .clk(clk), .rst_n(rst_n), .vl(vl), .whole_mode(whole_mode),
    .start_cmp(start_cmp), .start_comb(start_comb), .start_fadd(start_fadd),
    .cmp_issue(cmp_issue), .cmp_group(cmp_group),
    .comb_issue(comb_issue), .comb_whole(comb_whole), .comb_group(comb_group),
    .fadd_issue(fadd_issue), .fadd_group(fadd_group), .fadd_lanes(fadd_lanes),
    .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Runs one schedule and compares every group's issue cycle.
  // cs: first cycle the combine and FP add are active (0 = started with compare).
  task automatic run(input int len, input bit whole, input int cs);
    int g_n = (len + 3) / 4;
    int cmp_c[16], comb_c[16], fadd_c[16], lanes_last;
    int e_comb[16], e_fadd[16];
    int n_cmp = 0, n_comb = 0, n_fadd = 0, n_done = 0, done_c = -1, whole_seen = 0;
    int cw;
    foreach (cmp_c[i]) begin cmp_c[i] = -1; comb_c[i] = -1; fadd_c[i] = -1; end
    lanes_last = -1;
    @(negedge clk);
    vl = 7'(len); whole_mode = whole;
    start_cmp = 1'b1; start_comb = (cs == 0); start_fadd = (cs == 0);
    for (int t = 0; t < 90; t++) begin
      @(negedge clk);
      start_cmp = 1'b0;
      start_comb = (t == cs - 1); start_fadd = (t == cs - 1);
      if (cmp_issue)  begin n_cmp++;  cmp_c[cmp_group] = t; end
      if (comb_issue) begin n_comb++; comb_c[comb_group] = t; if (comb_whole) whole_seen++; end
      if (fadd_issue) begin
        n_fadd++; fadd_c[fadd_group] = t;
        if (int'(fadd_group) == g_n - 1) lanes_last = int'(fadd_lanes);
      end
      if (done) begin n_done++; done_c = t; end
    end
    start_comb = 1'b0; start_fadd = 1'b0;

    if (g_n == 0) begin
      chk("R9 no compare issue", n_cmp, 0);
      chk("R9 no combine issue", n_comb, 0);
      chk("R9 no fadd issue", n_fadd, 0);
      chk("R9 no done", n_done, 0);
      return;
    end

    chk("R2 compare issue count", n_cmp, g_n);
    for (int g = 0; g < g_n; g++) chk($sformatf("R2 compare group %0d cycle", g), cmp_c[g], g);

    if (!whole) begin
      for (int g = 0; g < g_n; g++) begin
        e_comb[g] = (g + 1 > cs) ? g + 1 : cs;
        if (g > 0 && e_comb[g - 1] + 1 > e_comb[g]) e_comb[g] = e_comb[g - 1] + 1;
        e_fadd[g] = e_comb[g] + 1;
        if (g > 0 && e_fadd[g - 1] + 1 > e_fadd[g]) e_fadd[g] = e_fadd[g - 1] + 1;
      end
      chk("R4 combine issue count", n_comb, g_n);
      for (int g = 0; g < g_n; g++) begin
        chk($sformatf("R4 combine group %0d cycle", g), comb_c[g], e_comb[g]);
        chk($sformatf("R5 fadd group %0d cycle", g), fadd_c[g], e_fadd[g]);
      end
    end else begin
      cw = (g_n > cs) ? g_n : cs;
      chk("R6 single whole combine", n_comb, 1);
      chk("R6 combine flagged whole", whole_seen, 1);
      chk("R6 whole combine cycle", comb_c[0], cw);
      for (int g = 0; g < g_n; g++)
        chk($sformatf("R7 fadd group %0d cycle", g), fadd_c[g], cw + 1 + g);
    end
    chk("R5 fadd issue count", n_fadd, g_n);
    chk("R3 last group lanes", lanes_last, (len % 4 == 0) ? 15 : (1 << (len % 4)) - 1);
    chk("R8 single done pulse", n_done, 1);
    chk("R8 done cycle", done_c, fadd_c[g_n - 1] + 1);
  endtask

  task automatic reset_test;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 no issue in reset", int'({cmp_issue, comb_issue, fadd_issue}), 0);
    chk("R1 no done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'({cmp_issue, comb_issue, fadd_issue, done}), 0);
  endtask

  initial begin
    reset_test();
    run(20, 1'b0, 0);
    run(20, 1'b1, 0);
    run(18, 1'b0, 0);
    run(18, 1'b1, 0);
    run(20, 1'b0, 3);
    run(20, 1'b1, 7);
    run(64, 1'b0, 0);
    run(64, 1'b1, 0);
    run(1, 1'b0, 0);
    run(0, 1'b0, 0);
    summary();
  end

  initial begin
    wait (cycles > 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
    summary();
  end
endmodule